// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block produces four independent pulse-width modulated outputs from one clock. Software programs it over a plain 32-bit register bus with a write strobe, a byte address and write data. Reads are combinational from the address. A shared control word turns each channel on and picks its clock divider. Each channel has its own word that packs the period length in ticks and the high time in ticks.

Each running channel counts divided-clock ticks from zero. It wraps back to zero at the end of its period, and its pin is high while the count is below the high-time value. Period and high-time values written while a channel runs are held in a shadow register. They take effect only at the next period boundary, so no period is cut short or stretched. A separate steering register can give a pin over to another function. When it does, the pin is held low here.

A period field of zero gives the full 65536-tick period.

Top module: `quad_pwm`

## Requirements
- R1: After reset every output pin is low and every register reads zero.
- R2: Register readback returns the defined fields of the last value written. These are the control word at byte offset 0x000, the channel word for channel n at byte offset 0x004 + 4n (all 32 bits), and the steering word at byte offset 0x140. In the control word, bit n is the enable for channel n and bits 2n+5:2n+4 are its divider select. In the steering word, bit 4n belongs to channel n. All other bits of the control and steering words read zero.
- R3: A write to any other byte offset, including an offset that is not 4-byte aligned, changes no register and no output, and a read from such an offset returns zero.
- R4: With divider select 0, an enabled channel has a period of P clocks and stays high for the first H clocks of each period. P is the low 16 bits of its channel word and H is the high 16 bits. Its first period starts in the clock after the enabling write.
- R5: Divider selects 1, 2 and 3 stretch every tick to 8, 64 and 512 clocks, so the period and the high time scale by that factor.
- R6: A high-time value equal to or above the period value gives a constant-high pin, and a high-time of zero gives a constant-low pin.
- R7: Clearing a channel's enable bit drives its pin low in the next clock. Enabling the channel again restarts its period and its divider from zero.
- R8: A new channel word written while the channel runs leaves the current period unchanged. The new period and high time start at the next period boundary.
- R9: Setting a channel's steering bit holds its pin low without stopping its counter. Clearing the bit restores the waveform in step with the uninterrupted count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one write per asserted clock |
| addr | input | 9 | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| pwmOut | output | 4 | Channel output pins, bit n for channel n |

## Verification
A counter or divider left in a wrong state shows up directly at the pin. Within one period, the high or low run is the wrong length or the edges are offset. The bench compares every pin in every clock against waveforms computed from the requirements, so such an error is caught on the first wrong cycle. A shadow value taken over at the wrong moment shows up as a period of the wrong length right around the reprogramming write. A steering or enable bit lost inside the register file shows up in the same cycle as a pin that should be low but is not.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;
  localparam int TbW = 16;
  localparam int StageW = 3;

  typedef struct packed {
    logic           en;
    logic [1:0]     presc;
    logic           altMode;
    logic [TbW-1:0] period;
    logic [TbW-1:0] high;
  } chanCfgT;
endpackage

// File: rtl/quad_pwm_regs.sv
module quad_pwm_regs
  import quad_pwm_pkg::*;
#(
  parameter int NumCh = 4,
  parameter int AddrW = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [AddrW-1:0]       addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output chanCfgT [NumCh-1:0]    chCfg
);
  localparam logic [AddrW-1:0] CtrlOff  = AddrW'(0);
  localparam logic [AddrW-1:0] CfgBase  = AddrW'(4);
  localparam logic [AddrW-1:0] ModeOff  = AddrW'(9'h140);
  localparam int               PrescLsb = 4;
  localparam int               ModeStep = 4;

  logic [NumCh-1:0]            enReg;
  logic [NumCh-1:0][1:0]       prescReg;
  logic [NumCh-1:0]            modeReg;
  logic [NumCh-1:0][2*TbW-1:0] wordReg;
  logic [NumCh-1:0]            chHit;
  logic                        ctrlHit;
  logic                        modeHit;

  assign ctrlHit = (addr == CtrlOff);
  assign modeHit = (addr == ModeOff);

  for (genvar i = 0; i < NumCh; i++) begin : g_dec
    assign chHit[i] = (addr == CfgBase + AddrW'(4 * i));
    assign chCfg[i].en      = enReg[i];
    assign chCfg[i].presc   = prescReg[i];
    assign chCfg[i].altMode = modeReg[i];
    assign chCfg[i].period  = wordReg[i][TbW-1:0];
    assign chCfg[i].high    = wordReg[i][2*TbW-1:TbW];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= '0;
      prescReg <= '0;
      modeReg  <= '0;
      wordReg  <= '0;
    end else if (wrEn) begin
      for (int i = 0; i < NumCh; i++) begin
        if (ctrlHit) begin
          enReg[i]    <= wdata[i];
          prescReg[i] <= wdata[PrescLsb + 2*i +: 2];
        end
        if (modeHit) modeReg[i] <= wdata[ModeStep*i];
        if (chHit[i]) wordReg[i] <= wdata[2*TbW-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NumCh; i++) begin
      if (ctrlHit) begin
        rdata[i]                     = enReg[i];
        rdata[PrescLsb + 2*i +: 2]   = prescReg[i];
      end
      if (modeHit) rdata[ModeStep*i] = modeReg[i];
      if (chHit[i]) rdata[2*TbW-1:0] = wordReg[i];
    end
  end
endmodule

// File: rtl/quad_pwm_core.sv
module quad_pwm_core
  import quad_pwm_pkg::*;
#(
  parameter int NumCh = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  chanCfgT [NumCh-1:0] chCfg,
  output logic [NumCh-1:0]    pwmOut
);
  localparam int DivW = 3 * StageW;

  for (genvar g = 0; g < NumCh; g++) begin : g_ch
    logic [DivW-1:0] divCnt;
    logic [TbW-1:0]  cnt;
    logic [TbW-1:0]  actTb;
    logic [TbW-1:0]  actHigh;
    logic            tick;
    logic            wrapNow;

    always_comb begin
      case (chCfg[g].presc)
        2'd0:    tick = 1'b1;
        2'd1:    tick = &divCnt[StageW-1:0];
        2'd2:    tick = &divCnt[2*StageW-1:0];
        default: tick = &divCnt;
      endcase
    end

    assign wrapNow = tick && (cnt == actTb - TbW'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        divCnt  <= '0;
        cnt     <= '0;
        actTb   <= '0;
        actHigh <= '0;
      end else if (!chCfg[g].en) begin
        divCnt  <= '0;
        cnt     <= '0;
        actTb   <= chCfg[g].period;
        actHigh <= chCfg[g].high;
      end else begin
        divCnt <= divCnt + DivW'(1);
        if (wrapNow) begin
          cnt     <= '0;
          actTb   <= chCfg[g].period;
          actHigh <= chCfg[g].high;
        end else if (tick) begin
          cnt <= cnt + TbW'(1);
        end
      end
    end

    assign pwmOut[g] = chCfg[g].en && !chCfg[g].altMode && (cnt < actHigh);
  end
endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
  import quad_pwm_pkg::*;
#(
  parameter int NumCh = 4,
  parameter int AddrW = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [NumCh-1:0] pwmOut
);
  chanCfgT [NumCh-1:0] chCfg;

  quad_pwm_regs #(.NumCh(NumCh), .AddrW(AddrW)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .chCfg(chCfg)
  );

  quad_pwm_core #(.NumCh(NumCh)) u_core (
    .clk(clk), .rstN(rstN), .chCfg(chCfg), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/quad_pwm_chk.sv
module quad_pwm_chk
  import quad_pwm_pkg::*;
#(
  parameter int NumCh = 4,
  parameter int AddrW = 9
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [AddrW-1:0]    addr,
  input logic [31:0]         wdata,
  input logic [NumCh-1:0]    pwmOut,
  input chanCfgT [NumCh-1:0] chCfg
);
  logic mapped;
  always_comb begin
    mapped = (addr == AddrW'(0)) || (addr == AddrW'(9'h140));
    for (int i = 0; i < NumCh; i++)
      if (addr == AddrW'(4 + 4*i)) mapped = 1'b1;
  end

  p_reset_low_r1: assert property (@(posedge clk) !rstN |=> (pwmOut == '0));

  p_unmapped_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !mapped) |=> $stable(chCfg));

  for (genvar i = 0; i < NumCh; i++) begin : g_p
    p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == AddrW'(0)) |=> (chCfg[i].en == $past(wdata[i])));

    p_off_low_r7: assert property (@(posedge clk) disable iff (!rstN)
      !chCfg[i].en |-> !pwmOut[i]);

    p_steer_low_r9: assert property (@(posedge clk) disable iff (!rstN)
      chCfg[i].altMode |-> !pwmOut[i]);
  end
endmodule

bind quad_pwm quad_pwm_chk #(.NumCh(NumCh), .AddrW(AddrW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
  .wdata(wdata), .pwmOut(pwmOut), .chCfg(chCfg)
);

// File: tb/test_quad_pwm.sv
module test_quad_pwm;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwmOut;

  always #4 clk = ~clk;

  quad_pwm i_quad_pwm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwmOut(pwmOut)
  );

  typedef struct {
    bit          isRead;
    logic [3:0]  expOut;
    logic [31:0] expData;
    string       req;
  } itemT;
  itemT q[$];

  int  checks = 0, errors = 0, cyc = 0;
  bit  done = 0;
  int  tbM[4], dutyM[4], divM[4], startM[4], pendCyc[4], shTb[4], shDuty[4];
  bit  enM[4], modeM[4];

  function automatic logic [3:0] expVec();
    logic [3:0] v;
    for (int c = 0; c < 4; c++) begin
      int p, h, ph;
      p = (tbM[c] == 0) ? 65536 : tbM[c];
      h = (dutyM[c] < p) ? dutyM[c] : p;
      ph = (cyc - startM[c]) % (p * divM[c]);
      v[c] = enM[c] && !modeM[c] && (ph < h * divM[c]);
    end
    return v;
  endfunction

  task automatic tick();
    @(negedge clk);
    cyc++;
    for (int c = 0; c < 4; c++)
      if (pendCyc[c] == cyc) begin
        tbM[c] = shTb[c]; dutyM[c] = shDuty[c]; startM[c] = cyc; pendCyc[c] = -1;
      end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    tick();
    wrEn = 1'b0;
    if (a == 9'h000) begin
      for (int c = 0; c < 4; c++) begin
        int s;
        s = d[4 + 2*c +: 2];
        divM[c] = (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 64 : 512;
        if (d[c] && !enM[c]) startM[c] = cyc;
        if (!d[c]) begin tbM[c] = shTb[c]; dutyM[c] = shDuty[c]; pendCyc[c] = -1; end
        enM[c] = d[c];
      end
    end else if (a == 9'h140) begin
      for (int c = 0; c < 4; c++) modeM[c] = d[4*c];
    end else begin
      for (int c = 0; c < 4; c++)
        if (a == 9'(4 + 4*c)) begin
          shTb[c] = d[15:0]; shDuty[c] = d[31:16];
          if (enM[c]) begin
            int p;
            p = ((tbM[c] == 0) ? 65536 : tbM[c]) * divM[c];
            pendCyc[c] = startM[c] + ((cyc - startM[c]) / p + 1) * p;
          end else begin
            tbM[c] = shTb[c]; dutyM[c] = shDuty[c];
          end
        end
    end
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      itemT it;
      it.isRead = 0; it.expOut = expVec(); it.expData = '0; it.req = req;
      q.push_back(it);
      tick();
    end
  endtask

  task automatic rdChk(input logic [8:0] a, input logic [31:0] e, input string req);
    itemT it;
    addr = a;
    it.isRead = 1; it.expOut = '0; it.expData = e; it.req = req;
    q.push_back(it);
    tick();
  endtask

  initial forever begin
    @(negedge clk);
    #1;
    if (q.size() > 0) begin
      itemT it;
      it = q.pop_front();
      checks++;
      if (it.isRead) begin
        if (rdata !== it.expData) begin
          errors++;
          $display("FAIL %s rdata act %h exp %h", it.req, rdata, it.expData);
        end
      end else if (pwmOut !== it.expOut) begin
        errors++;
        $display("FAIL %s pwmOut act %b exp %b (cycle %0d)", it.req, pwmOut, it.expOut, cyc);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      tbM[c] = 0; dutyM[c] = 0; divM[c] = 1; startM[c] = 0; pendCyc[c] = -1;
      shTb[c] = 0; shDuty[c] = 0; enM[c] = 0; modeM[c] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
    // R1: reset state
    rdChk(9'h000, 32'h0, "R1");
    rdChk(9'h004, 32'h0, "R1");
    rdChk(9'h140, 32'h0, "R1");
    run(3, "R1");
    // R2: readback
    wr(9'h004, {16'd2, 16'd5});
    rdChk(9'h004, {16'd2, 16'd5}, "R2");
    wr(9'h010, 32'hABCD_1234);
    rdChk(9'h010, 32'hABCD_1234, "R2");
    wr(9'h010, 32'h0);
    wr(9'h140, 32'hFFFF_FFFF);
    rdChk(9'h140, 32'h0000_1111, "R2");
    wr(9'h140, 32'h0);
    rdChk(9'h140, 32'h0, "R2");
    // R3: unmapped offsets
    wr(9'h014, 32'hFFFF_FFFF);
    wr(9'h141, 32'hFFFF_FFFF);
    wr(9'h001, 32'hFFFF_FFFF);
    rdChk(9'h014, 32'h0, "R3");
    rdChk(9'h000, 32'h0, "R3");
    rdChk(9'h140, 32'h0, "R3");
    rdChk(9'h004, {16'd2, 16'd5}, "R3");
    run(4, "R3");
    // R4: basic waveform, no division
    wr(9'h000, 32'h1);
    run(20, "R4");
    // R8: reprogram while running
    wr(9'h004, {16'd3, 16'd4});
    run(30, "R8");
    // R6: duty at or above period, duty zero
    wr(9'h000, 32'h0);
    wr(9'h004, {16'd7, 16'd4});
    wr(9'h000, 32'h1);
    run(12, "R6");
    wr(9'h000, 32'h0);
    wr(9'h004, {16'd0, 16'd4});
    wr(9'h000, 32'h1);
    run(12, "R6");
    // R7: disable holds low, re-enable restarts
    wr(9'h000, 32'h0);
    wr(9'h004, {16'd2, 16'd6});
    wr(9'h000, 32'h1);
    run(3, "R7");
    wr(9'h000, 32'h0);
    run(5, "R7");
    wr(9'h000, 32'h1);
    run(8, "R7");
    // R5: divider selects
    wr(9'h008, {16'd1, 16'd3});
    wr(9'h00C, {16'd1, 16'd2});
    wr(9'h010, {16'd1, 16'd2});
    wr(9'h000, 32'h0000_0E4F);
    run(2100, "R5");
    rdChk(9'h000, 32'h0000_0E4F, "R2");
    // R9: steering
    wr(9'h140, 32'h0000_0010);
    run(50, "R9");
    wr(9'h140, 32'h0);
    run(50, "R9");
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule